// File: doc/BRIEF.md
# HDLC Event Status Register

This block gathers one-cycle event pulses coming from an HDLC transmitter, an HDLC receiver and their FIFOs, and holds them in a single 8-bit status register. A host reads that register over a minimal register bus: it raises a read strobe, samples the value, and the register clears behind it. Each bit remembers its event until it has been read. An event that lands in the same cycle as a read is kept for the next read, so no event is lost.

Bit 2 is shared between two event sources. A control input selects whether it reports a qualified receive abort or a transmit FIFO underrun. A receive abort counts only when the current packet has already delivered a minimum number of bits (26 by default). An 8-bit mask register, written by the host, selects which status bits drive the interrupt output.

Top module: `hdlc_evt_status`

## Requirements
- R1: After synchronous reset, `rd_data` is 8'h00, the mask register is 8'h00 and `irq` is low.
- R2: A pulse on an event input sets its bit, and the bit is visible on `rd_data` in the cycle after the pulse. The bit positions are: 7 go-ahead, 6 receive end-of-packet, 5 transmit end-of-packet, 4 end-of-packet-read, 3 transmit FIFO low, 2 abort/underrun, 1 receive FIFO full, 0 receive FIFO overflow.
- R3: A set bit stays set in every cycle that has no read strobe.
- R4: `rd_data` shows the register continuously. In the cycle where `rd_stb` is high it shows the value before the read, and every bit is clear in the next cycle unless R5 applies.
- R5: An event that arrives in the same cycle as `rd_stb` leaves its bit set after the read.
- R6: With `sel_underrun` = 0, bit 2 is set only by a qualified receive abort, and `ev_tx_underrun` has no effect.
- R7: With `sel_underrun` = 1, bit 2 is set only by `ev_tx_underrun`, and `ev_rx_abort` has no effect on any bit.
- R8: A receive abort is qualified only when at least 26 cycles with `rx_bit_valid` high have occurred after the most recent `rx_pkt_start` and before the abort cycle. `rx_pkt_start` resets this count to zero, and a bit strobe in the same cycle as `rx_pkt_start` is not counted. Before the first `rx_pkt_start` the count is zero.
- R9: `irq` is high exactly when some status bit is set and its mask bit is 1. A `mask_wr` loads `mask_wdata` at the clock edge, so the new mask acts from the next cycle.
- R10: With a mask of 8'h00, `irq` stays low whatever the status bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_go_ahead | input | 1 | Receiver saw a go-ahead pattern |
| ev_rx_eop | input | 1 | Receiver wrote an end-of-packet byte into its FIFO |
| ev_tx_eop | input | 1 | Transmitter finished a closing flag or an abort |
| ev_eop_read | input | 1 | Next receive FIFO byte ends a packet, or a read hit an empty FIFO |
| ev_tx_low | input | 1 | Transmit FIFO dropped below its low threshold |
| ev_rx_abort | input | 1 | Receiver detected an abort sequence |
| ev_tx_underrun | input | 1 | Transmitter read an empty transmit FIFO |
| ev_rx_full | input | 1 | Receive FIFO rose above its full threshold |
| ev_rx_overflow | input | 1 | Receive FIFO was written while full |
| rx_pkt_start | input | 1 | Receiver started a new packet (opening flag) |
| rx_bit_valid | input | 1 | Receiver accepted one packet bit |
| sel_underrun | input | 1 | Source select for bit 2: 0 abort, 1 underrun |
| mask_wr | input | 1 | Write strobe for the interrupt mask |
| mask_wdata | input | 8 | Mask value to write |
| rd_stb | input | 1 | Host read strobe, clears the status at the edge |
| rd_data | output | 8 | Current status register value |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions check on every cycle that set bits are sticky without a read, that a read with no coinciding event empties the register, that the go-ahead, receive end-of-packet and selected underrun pulses appear one cycle later, that a selected underrun is never dropped at a read, and that `irq` is low whenever the register is empty. The 26-bit qualification window, the switching between sources on the shared bit and the effect of mask writes depend on history the properties do not track. Only the bench's scenarios and its cycle-by-cycle reference model can show them, using packets with 25 and 26 bits, aborts issued under each select value and several mask patterns.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;

    localparam int STAT_W         = 8;
    localparam int MIN_ABORT_BITS = 26;

    localparam int B_GO_AHEAD = 7;
    localparam int B_RX_EOP   = 6;
    localparam int B_TX_EOP   = 5;
    localparam int B_EOP_READ = 4;
    localparam int B_TX_LOW   = 3;
    localparam int B_SHARED   = 2;
    localparam int B_RX_FULL  = 1;
    localparam int B_RX_OVF   = 0;

    typedef enum logic {
        SRC_ABORT    = 1'b0,
        SRC_UNDERRUN = 1'b1
    } shared_src_e;

    typedef struct packed {
        logic go_ahead;
        logic rx_eop;
        logic tx_eop;
        logic eop_read;
        logic tx_low;
        logic rx_abort_ok;
        logic tx_underrun;
        logic rx_full;
        logic rx_ovf;
    } evt_t;

    function automatic logic [STAT_W-1:0] evt_to_vec(evt_t e, shared_src_e src);
        logic [STAT_W-1:0] v;
        v             = '0;
        v[B_GO_AHEAD] = e.go_ahead;
        v[B_RX_EOP]   = e.rx_eop;
        v[B_TX_EOP]   = e.tx_eop;
        v[B_EOP_READ] = e.eop_read;
        v[B_TX_LOW]   = e.tx_low;
        v[B_SHARED]   = (src == SRC_UNDERRUN) ? e.tx_underrun : e.rx_abort_ok;
        v[B_RX_FULL]  = e.rx_full;
        v[B_RX_OVF]   = e.rx_ovf;
        return v;
    endfunction

endpackage

// File: rtl/hdlc_abort_qual.sv
module hdlc_abort_qual #(
    parameter int MIN_BITS = 26
) (
    input  logic clk,
    input  logic rst,
    input  logic pkt_start,
    input  logic bit_valid,
    input  logic abort_in,
    output logic abort_ok
);
    localparam int CW = $clog2(MIN_BITS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_BITS);

    logic [CW-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
        end else if (pkt_start) begin
            bit_cnt <= '0;
        end else if (bit_valid && (bit_cnt != LIMIT)) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign abort_ok = abort_in && (bit_cnt == LIMIT);

endmodule

// File: rtl/hdlc_sticky_bits.sv
module hdlc_sticky_bits #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr_all,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                q[i] <= 1'b1;
            end else if (clr_all) begin
                q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hdlc_irq_mask.sv
module hdlc_irq_mask #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr) begin
            mask_q <= wdata;
        end
    end

    assign irq = |(status & mask_q);

endmodule

// File: rtl/hdlc_evt_status.sv
module hdlc_evt_status
    import hdlc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_go_ahead,
    input  logic              ev_rx_eop,
    input  logic              ev_tx_eop,
    input  logic              ev_eop_read,
    input  logic              ev_tx_low,
    input  logic              ev_rx_abort,
    input  logic              ev_tx_underrun,
    input  logic              ev_rx_full,
    input  logic              ev_rx_overflow,
    input  logic              rx_pkt_start,
    input  logic              rx_bit_valid,
    input  logic              sel_underrun,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] rd_data,
    output logic              irq
);
    logic              abort_ok;
    evt_t              evt;
    shared_src_e       src;
    logic [STAT_W-1:0] set_vec;

    hdlc_abort_qual #(
        .MIN_BITS (MIN_ABORT_BITS)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .pkt_start (rx_pkt_start),
        .bit_valid (rx_bit_valid),
        .abort_in  (ev_rx_abort),
        .abort_ok  (abort_ok)
    );

    always_comb begin
        evt.go_ahead    = ev_go_ahead;
        evt.rx_eop      = ev_rx_eop;
        evt.tx_eop      = ev_tx_eop;
        evt.eop_read    = ev_eop_read;
        evt.tx_low      = ev_tx_low;
        evt.rx_abort_ok = abort_ok;
        evt.tx_underrun = ev_tx_underrun;
        evt.rx_full     = ev_rx_full;
        evt.rx_ovf      = ev_rx_overflow;
        src             = sel_underrun ? SRC_UNDERRUN : SRC_ABORT;
        set_vec         = evt_to_vec(evt, src);
    end

    hdlc_sticky_bits #(
        .W (STAT_W)
    ) u_bits (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_all (rd_stb),
        .q       (rd_data)
    );

    hdlc_irq_mask #(
        .W (STAT_W)
    ) u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr     (mask_wr),
        .wdata  (mask_wdata),
        .status (rd_data),
        .irq    (irq)
    );

endmodule

// File: rtl/hdlc_evt_status_chk.sv
module hdlc_evt_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       ev_go_ahead,
    input logic       ev_rx_eop,
    input logic       ev_tx_eop,
    input logic       ev_eop_read,
    input logic       ev_tx_low,
    input logic       ev_rx_abort,
    input logic       ev_tx_underrun,
    input logic       ev_rx_full,
    input logic       ev_rx_overflow,
    input logic       sel_underrun,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       irq
);
    logic any_evt;
    assign any_evt = ev_go_ahead | ev_rx_eop | ev_tx_eop | ev_eop_read | ev_tx_low |
                     ev_rx_abort | ev_tx_underrun | ev_rx_full | ev_rx_overflow;

    // R1: register empty in the cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00));

    // R3: bits held when no read
    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

    // R4: read with no event empties the register
    assert_read_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !any_evt) |=> (rd_data == 8'h00));

    // R2: go-ahead and receive end-of-packet land one cycle later
    assert_go_ahead_R2: assert property (@(posedge clk) disable iff (rst)
        ev_go_ahead |=> rd_data[7]);

    assert_rx_eop_R2: assert property (@(posedge clk) disable iff (rst)
        ev_rx_eop |=> rd_data[6]);

    // R5 and R7: selected underrun survives a coinciding read
    assert_underrun_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_underrun && ev_tx_underrun) |=> rd_data[2]);

    // R9: no interrupt from an empty register
    assert_irq_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_data == 8'h00) |-> !irq);

endmodule

bind hdlc_evt_status hdlc_evt_status_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ev_go_ahead    (ev_go_ahead),
    .ev_rx_eop      (ev_rx_eop),
    .ev_tx_eop      (ev_tx_eop),
    .ev_eop_read    (ev_eop_read),
    .ev_tx_low      (ev_tx_low),
    .ev_rx_abort    (ev_rx_abort),
    .ev_tx_underrun (ev_tx_underrun),
    .ev_rx_full     (ev_rx_full),
    .ev_rx_overflow (ev_rx_overflow),
    .sel_underrun   (sel_underrun),
    .rd_stb         (rd_stb),
    .rd_data        (rd_data),
    .irq            (irq)
);

// File: tb/tb_hdlc_evt_status.sv
`timescale 1ns/1ps
module tb_hdlc_evt_status;
    logic       clk = 1'b0;
    logic       rst;
    logic       ev_go_ahead, ev_rx_eop, ev_tx_eop, ev_eop_read, ev_tx_low;
    logic       ev_rx_abort, ev_tx_underrun, ev_rx_full, ev_rx_overflow;
    logic       rx_pkt_start, rx_bit_valid, sel_underrun, mask_wr, rd_stb;
    logic [7:0] mask_wdata;
    logic [7:0] rd_data;
    logic       irq;

    always #2 clk = ~clk;   // 250 MHz

    hdlc_evt_status dut (
        .clk(clk), .rst(rst),
        .ev_go_ahead(ev_go_ahead), .ev_rx_eop(ev_rx_eop), .ev_tx_eop(ev_tx_eop),
        .ev_eop_read(ev_eop_read), .ev_tx_low(ev_tx_low), .ev_rx_abort(ev_rx_abort),
        .ev_tx_underrun(ev_tx_underrun), .ev_rx_full(ev_rx_full),
        .ev_rx_overflow(ev_rx_overflow), .rx_pkt_start(rx_pkt_start),
        .rx_bit_valid(rx_bit_valid), .sel_underrun(sel_underrun),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .rd_stb(rd_stb),
        .rd_data(rd_data), .irq(irq)
    );

    int     n_checks = 0;
    int     n_fail   = 0;
    string  cur_req  = "R1";
    logic [7:0] m_stat = 8'h00;
    logic [7:0] m_mask = 8'h00;
    int     m_bits = 0;
    bit     done = 0;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_pulses();
        ev_go_ahead = 0; ev_rx_eop = 0; ev_tx_eop = 0; ev_eop_read = 0;
        ev_tx_low = 0; ev_rx_abort = 0; ev_tx_underrun = 0; ev_rx_full = 0;
        ev_rx_overflow = 0; rx_pkt_start = 0; rx_bit_valid = 0;
        mask_wr = 0; rd_stb = 0;
    endtask

    // one clock: reference model updates at the edge, outputs compared at negedge
    task automatic step();
        logic [7:0] setv;
        @(posedge clk);
        if (rst) begin
            m_stat = 8'h00; m_mask = 8'h00; m_bits = 0;
        end else begin
            setv = {ev_go_ahead, ev_rx_eop, ev_tx_eop, ev_eop_read, ev_tx_low,
                    (sel_underrun ? ev_tx_underrun : (ev_rx_abort && m_bits >= 26)),
                    ev_rx_full, ev_rx_overflow};
            m_stat = rd_stb ? setv : (m_stat | setv);
            if (mask_wr) m_mask = mask_wdata;
            if (rx_pkt_start) m_bits = 0;
            else if (rx_bit_valid) m_bits++;
        end
        @(negedge clk);
        check(cur_req, rd_data, m_stat);
        check(cur_req, {7'd0, irq}, {7'd0, |(m_stat & m_mask)});
        clear_pulses();
    endtask

    task automatic read_clear();
        rd_stb = 1; step();
    endtask

    task automatic feed_bits(int n);
        rx_pkt_start = 1; step();
        for (int i = 0; i < n; i++) begin rx_bit_valid = 1; step(); end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        clear_pulses();
        sel_underrun = 0; mask_wdata = 8'h00; rst = 1;
        cur_req = "R1";
        step(); step();
        rst = 0;
        step();
        check("R1", rd_data, 8'h00);

        // R2: each event alone, then read it out
        cur_req = "R2";
        for (int b = 0; b < 8; b++) begin
            case (b)
                0: ev_rx_overflow = 1;
                1: ev_rx_full = 1;
                2: begin sel_underrun = 1; ev_tx_underrun = 1; end
                3: ev_tx_low = 1;
                4: ev_eop_read = 1;
                5: ev_tx_eop = 1;
                6: ev_rx_eop = 1;
                default: ev_go_ahead = 1;
            endcase
            step();
            check("R2", rd_data, 8'(1 << b));
            read_clear();
            sel_underrun = 0;
        end

        // R3: hold over idle cycles
        cur_req = "R3";
        ev_go_ahead = 1; ev_tx_low = 1; step();
        repeat (5) step();
        check("R3", rd_data, 8'h88);

        // R4: value visible during read, cleared after
        cur_req = "R4";
        rd_stb = 1;
        #0 check("R4", rd_data, 8'h88);
        step();
        check("R4", rd_data, 8'h00);

        // R5: event coinciding with read
        cur_req = "R5";
        ev_rx_full = 1; step();
        rd_stb = 1; ev_rx_eop = 1; step();
        check("R5", rd_data, 8'h40);
        read_clear();

        // R8/R6: abort after 25 bits ignored, after 26 taken
        cur_req = "R8";
        feed_bits(25);
        ev_rx_abort = 1; step();
        check("R8", rd_data, 8'h00);
        feed_bits(26);
        ev_rx_abort = 1; step();
        check("R8", rd_data, 8'h04);
        read_clear();
        cur_req = "R6";
        ev_tx_underrun = 1; step();
        check("R6", rd_data, 8'h00);

        // R7: underrun selected, abort ignored even when qualified
        cur_req = "R7";
        feed_bits(30);
        sel_underrun = 1; ev_rx_abort = 1; step();
        check("R7", rd_data, 8'h00);
        ev_tx_underrun = 1; step();
        check("R7", rd_data, 8'h04);
        read_clear();
        sel_underrun = 0;

        // R10: zero mask keeps irq low
        cur_req = "R10";
        ev_go_ahead = 1; ev_rx_overflow = 1; step();
        check("R10", {7'd0, irq}, 8'h00);
        read_clear();

        // R9: mask patterns
        cur_req = "R9";
        mask_wr = 1; mask_wdata = 8'h02; step();
        ev_rx_overflow = 1; step();
        check("R9", {7'd0, irq}, 8'h00);
        ev_rx_full = 1; step();
        check("R9", {7'd0, irq}, 8'h01);
        read_clear();
        check("R9", {7'd0, irq}, 8'h00);

        // mixed random traffic against the reference model
        cur_req = "R2";
        for (int c = 0; c < 2000; c++) begin
            ev_go_ahead    = ($urandom % 8) == 0;
            ev_rx_eop      = ($urandom % 8) == 0;
            ev_tx_eop      = ($urandom % 8) == 0;
            ev_eop_read    = ($urandom % 8) == 0;
            ev_tx_low      = ($urandom % 8) == 0;
            ev_rx_abort    = ($urandom % 6) == 0;
            ev_tx_underrun = ($urandom % 6) == 0;
            ev_rx_full     = ($urandom % 8) == 0;
            ev_rx_overflow = ($urandom % 8) == 0;
            rx_pkt_start   = ($urandom % 40) == 0;
            rx_bit_valid   = ($urandom % 4) != 0;
            rd_stb         = ($urandom % 5) == 0;
            mask_wr        = ($urandom % 30) == 0;
            mask_wdata     = 8'($urandom);
            if (($urandom % 50) == 0) sel_underrun = ~sel_underrun;
            step();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule